// File: doc/BRIEF.md
# Hybrid Stochastic-Binary Dot-Product Accumulator

This block produces one element of a vector-matrix product from unipolar stochastic bitstreams. On every cycle that carries data it receives one bit from each of ROW vector streams and one bit from each of ROW matrix streams. The bits are paired and multiplied with AND gates. The ROW products are then merged into a single stream by a balanced tree of 2:1 multiplexers, and each level of the tree is steered by its own pseudo-random select bit. The merged stream is an estimate of the mean of the ROW products.

A counter of ones turns the merged stream back into a binary number over one batch, which is a run of data cycles closed by a batch-end strobe. At the close, the count moves into a holding register and the counter restarts in the same cycle, so the next batch streams in while the previous count is scaled by ROW and added into a binary accumulator. When the closing batch carries the last-batch flag, the accumulated sum comes out with a one-cycle valid pulse and the accumulator starts from zero for the next output. The result is in units of ones per stream length.

Top module: `sc_dot_accum`

## Requirements
- R1: The product of lane i is `vec_bits[i] & mat_bits[i]`. With ROW = 1 the result is the exact number of cycles in which both lane-0 bits were 1, summed over the batches of the output.
- R2: The merge tree has log2(ROW) levels. Level 0 pairs lanes (2j, 2j+1), and each higher level pairs the outputs of the level below in the same way. A select bit of 1 passes the higher-indexed input. The select of level k is bit 0 of a 16-bit register. That register has reset value 16'hACE1 XOR (k * 16'h3B1D), truncated to 16 bits, and on every data cycle it steps to `{s[14:0], s[15]^s[13]^s[12]^s[10]}`.
- R3: When every lane product is 1 for a whole batch, that batch adds length*ROW. When every product is 0, it adds nothing, whatever the selects are.
- R4: Each batch adds (ones count << log2(ROW)) to the accumulator, and the output is the sum of these terms over all batches up to and including the one flagged last.
- R5: For a batch whose final data cycle has `batch_end` and `last_batch` high, `result_valid` is high for exactly the cycle after the third rising edge counted from the edge that samples that final bit.
- R6: After a result is delivered, the next output starts from zero and holds no part of earlier outputs.
- R7: The ones counter restarts on the edge that closes a batch. Batches may follow each other with no gap cycles, and a batch may be one bit long.
- R8: A cycle with `in_valid` low changes neither the ones count nor any select register.
- R9: During and immediately after reset, `result_valid` and `result` are 0.
- R10: `batch_end` and `last_batch` are ignored in cycles where `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Lane bits are valid this cycle |
| batch_end | input | 1 | This data cycle is the final bit of a batch |
| last_batch | input | 1 | With batch_end: the batch closes the current output |
| vec_bits | input | ROW | One bit per lane from the vector streams |
| mat_bits | input | ROW | One bit per lane from the matrix streams |
| result | output | ACC_W | Accumulated output, held until the next one |
| result_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench builds two copies of the block side by side. One has ROW = 8, so the three-level select tree and the shift by three are exercised. The other has ROW = 1, where the tree is absent and the output is an exact count of AND coincidences. Both use MAX_LEN = 64. Together they allow exact expected values under random streams, saturated and empty batches, one-bit batches back to back, idle gaps, and strobes that arrive without data.

// File: rtl/sc_dot_pkg.sv
package sc_dot_pkg;
   localparam int SEL_LFSR_W = 16;

   function automatic logic [SEL_LFSR_W-1:0] sel_lfsr_next(input logic [SEL_LFSR_W-1:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   function automatic logic [SEL_LFSR_W-1:0] sel_lfsr_seed(input int level);
      logic [SEL_LFSR_W-1:0] mix;
      mix = SEL_LFSR_W'(level) * 16'h3B1D;
      return 16'hACE1 ^ mix;
   endfunction
endpackage

// File: rtl/sc_sel_lfsr.sv
module sc_sel_lfsr
   import sc_dot_pkg::*;
#(
   parameter int LEVEL = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   output logic sel
);
   localparam logic [SEL_LFSR_W-1:0] SEED = sel_lfsr_seed(LEVEL);

   logic [SEL_LFSR_W-1:0] state;

   always_ff @(posedge clk) begin
      if (!rst_n)   state <= SEED;
      else if (adv) state <= sel_lfsr_next(state);
   end

   assign sel = state[0];
endmodule

// File: rtl/sc_mux_tree.sv
module sc_mux_tree #(
   parameter int ROW = 8,
   localparam int LOG_ROW = $clog2(ROW)
) (
   input  logic [ROW-1:0]     prod,
   input  logic [LOG_ROW-1:0] sel,
   output logic               merged
);
   // heap layout: node 1 is the root, nodes ROW..2*ROW-1 are the lanes
   logic [2*ROW-1:1] node;

   assign node[2*ROW-1:ROW] = prod;

   for (genvar d = 0; d < LOG_ROW; d++) begin : g_depth
      localparam int LVL = LOG_ROW - 1 - d;
      for (genvar i = (1 << d); i < (2 << d); i++) begin : g_node
         assign node[i] = sel[LVL] ? node[2*i+1] : node[2*i];
      end
   end

   assign merged = node[1];
endmodule

// File: rtl/sc_ones_counter.sv
module sc_ones_counter #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid,
   input  logic             bit_in,
   input  logic             close,
   input  logic             last,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] held,
   output logic             held_vld,
   output logic             held_last
);
   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc = cnt + CNT_W'(bit_in);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         held      <= '0;
         held_vld  <= 1'b0;
         held_last <= 1'b0;
      end else begin
         held_vld  <= valid & close;
         held_last <= valid & close & last;
         if (valid && close) begin
            held <= cnt_inc;
            cnt  <= '0;
         end else if (valid) begin
            cnt  <= cnt_inc;
         end
      end
   end
endmodule

// File: rtl/sc_bin_accum.sv
module sc_bin_accum #(
   parameter int CNT_W   = 7,
   parameter int LOG_ROW = 3,
   parameter int ACC_W   = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] held,
   input  logic             held_vld,
   input  logic             held_last,
   output logic [ACC_W-1:0] result,
   output logic             result_valid
);
   logic [ACC_W-1:0] acc;
   logic             fin;
   logic [ACC_W-1:0] addend;
   logic [ACC_W-1:0] base;

   assign addend = held_vld ? (ACC_W'(held) << LOG_ROW) : '0;
   assign base   = fin ? '0 : acc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc          <= '0;
         fin          <= 1'b0;
         result       <= '0;
         result_valid <= 1'b0;
      end else begin
         acc          <= base + addend;
         fin          <= held_vld & held_last;
         result_valid <= fin;
         if (fin) result <= acc;
      end
   end
endmodule

// File: rtl/sc_dot_accum.sv
module sc_dot_accum #(
   parameter int ROW     = 8,
   parameter int MAX_LEN = 64,
   parameter int ACC_W   = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             batch_end,
   input  logic             last_batch,
   input  logic [ROW-1:0]   vec_bits,
   input  logic [ROW-1:0]   mat_bits,
   output logic [ACC_W-1:0] result,
   output logic             result_valid
);
   localparam int LOG_ROW = $clog2(ROW);
   localparam int CNT_W   = $clog2(MAX_LEN + 1);

   if (ROW < 1 || ROW > 1024 || (ROW & (ROW - 1)) != 0) begin : g_bad_row
      $error("sc_dot_accum: ROW must be a power of two in 1..1024");
   end
   if (ACC_W < CNT_W + LOG_ROW) begin : g_bad_acc
      $error("sc_dot_accum: ACC_W too narrow for one scaled batch");
   end

   logic [ROW-1:0]   prod;
   logic             merged;
   logic [CNT_W-1:0] ones_cnt;
   logic [CNT_W-1:0] held;
   logic             held_vld;
   logic             held_last;

   assign prod = vec_bits & mat_bits;

   if (LOG_ROW == 0) begin : g_direct
      assign merged = prod[0];
   end else begin : g_tree
      logic [LOG_ROW-1:0] sel;
      for (genvar k = 0; k < LOG_ROW; k++) begin : g_lvl
         sc_sel_lfsr #(.LEVEL(k)) u_sel (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (in_valid),
            .sel   (sel[k])
         );
      end
      sc_mux_tree #(.ROW(ROW)) u_tree (
         .prod   (prod),
         .sel    (sel),
         .merged (merged)
      );
   end

   sc_ones_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (in_valid),
      .bit_in    (merged),
      .close     (batch_end),
      .last      (last_batch),
      .cnt       (ones_cnt),
      .held      (held),
      .held_vld  (held_vld),
      .held_last (held_last)
   );

   sc_bin_accum #(.CNT_W(CNT_W), .LOG_ROW(LOG_ROW), .ACC_W(ACC_W)) u_acc (
      .clk          (clk),
      .rst_n        (rst_n),
      .held         (held),
      .held_vld     (held_vld),
      .held_last    (held_last),
      .result       (result),
      .result_valid (result_valid)
   );
endmodule

// File: rtl/sc_dot_accum_chk.sv
module sc_dot_accum_chk #(
   parameter int ROW   = 8,
   parameter int CNT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             batch_end,
   input logic             last_batch,
   input logic [ROW-1:0]   vec_bits,
   input logic [ROW-1:0]   mat_bits,
   input logic [CNT_W-1:0] ones_cnt,
   input logic             result_valid
);
   // R1: no coincident ones means nothing is counted
   p_and_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !batch_end && ((vec_bits & mat_bits) == '0)) |=> ones_cnt == $past(ones_cnt));

   // R8: idle cycles leave the count alone
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(ones_cnt));

   // R7: counter restarts when a batch closes
   p_batch_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && batch_end) |=> ones_cnt == '0);

   // R5: closing the last batch yields a pulse three edges later
   p_done_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && batch_end && last_batch) |=> ##2 result_valid);

   // R5: no pulse without a matching last batch
   p_done_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> $past(in_valid && batch_end && last_batch, 3));
endmodule

bind sc_dot_accum sc_dot_accum_chk #(.ROW(ROW), .CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .batch_end    (batch_end),
   .last_batch   (last_batch),
   .vec_bits     (vec_bits),
   .mat_bits     (mat_bits),
   .ones_cnt     (ones_cnt),
   .result_valid (result_valid)
);

// File: tb/sim_sc_dot_accum.sv
module sim_sc_dot_accum;
   localparam int ACC_W = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, batch_end = 1'b0, last_batch = 1'b0;
   logic [7:0] vec = '0, mat = '0;
   logic [ACC_W-1:0] res8, res1;
   logic rv8, rv1;

   always #2 clk = ~clk;

   sc_dot_accum #(.ROW(8), .MAX_LEN(64), .ACC_W(ACC_W)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .batch_end(batch_end),
      .last_batch(last_batch), .vec_bits(vec), .mat_bits(mat),
      .result(res8), .result_valid(rv8));

   sc_dot_accum #(.ROW(1), .MAX_LEN(64), .ACC_W(ACC_W)) u1 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .batch_end(batch_end),
      .last_batch(last_batch), .vec_bits(vec[0:0]), .mat_bits(mat[0:0]),
      .result(res1), .result_valid(rv1));

   int n_tests = 0, n_fail = 0, cyc = 0;
   string cur_req = "R9";

   // reference model state
   logic [15:0] lf [3];
   int cnt8 = 0, cnt1 = 0, acc8 = 0, acc1 = 0;
   int q_due[$], q_v8[$], q_v1[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check_eq(string req, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic check_cycle();
      bit due;
      due = (q_due.size() > 0) && (q_due[0] == cyc);
      check_eq({cur_req, " valid u0"}, int'(rv8), int'(due));
      check_eq({cur_req, " valid u1"}, int'(rv1), int'(due));
      if (due) begin
         check_eq({cur_req, " result u0"}, int'(res8), q_v8[0]);
         check_eq({cur_req, " result u1"}, int'(res1), q_v1[0]);
         void'(q_due.pop_front()); void'(q_v8.pop_front()); void'(q_v1.pop_front());
      end
   endtask

   task automatic model_step(bit v, logic [7:0] vb, logic [7:0] mb, bit be, bit lb);
      logic [7:0] p;
      if (!v) return;
      p = vb & mb;
      cnt1 += int'(p[0]);
      for (int k = 0; k < 3; k++) begin
         logic [7:0] q;
         q = '0;
         for (int j = 0; j < (8 >> (k + 1)); j++)
            q[j] = lf[k][0] ? p[2*j+1] : p[2*j];
         p = q;
         lf[k] = {lf[k][14:0], lf[k][15] ^ lf[k][13] ^ lf[k][12] ^ lf[k][10]};
      end
      cnt8 += int'(p[0]);
      if (be) begin
         acc8 += cnt8 * 8; acc1 += cnt1;
         cnt8 = 0; cnt1 = 0;
         if (lb) begin
            q_due.push_back(cyc + 3); q_v8.push_back(acc8); q_v1.push_back(acc1);
            acc8 = 0; acc1 = 0;
         end
      end
   endtask

   task automatic drive(bit v, logic [7:0] vb, logic [7:0] mb, bit be, bit lb);
      @(negedge clk);
      check_cycle();
      in_valid = v; vec = vb; mat = mb; batch_end = be; last_batch = lb;
      model_step(v, vb, mb, be, lb);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) drive(1'b0, '0, '0, 1'b0, 1'b0);
   endtask

   task automatic rand_batch(int len, bit lb);
      for (int i = 0; i < len; i++)
         drive(1'b1, 8'($urandom), 8'($urandom), i == len - 1, lb);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      for (int k = 0; k < 3; k++) lf[k] = 16'hACE1 ^ 16'(k * 16'h3B1D);
      repeat (4) @(negedge clk);
      // R9: reset state
      check_eq("R9 valid", int'(rv8) + int'(rv1), 0);
      check_eq("R9 result", int'(res8) + int'(res1), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R9 after release", int'(rv8) + int'(res8), 0);

      // R1/R2: random streams, three batches per output
      cur_req = "R2";
      for (int o = 0; o < 4; o++) begin
         rand_batch(16, 1'b0); rand_batch(12, 1'b0); rand_batch(20, 1'b1);
      end
      idle(5);

      // R3: saturated then empty batches
      cur_req = "R3";
      for (int i = 0; i < 10; i++) drive(1'b1, 8'hFF, 8'hFF, i == 9, 1'b1);
      idle(4);
      check_eq("R3 all-ones u0", int'(res8), 80);
      check_eq("R3 all-ones u1", int'(res1), 10);
      for (int i = 0; i < 10; i++) drive(1'b1, 8'hF0, 8'h0F, i == 9, 1'b1);
      idle(4);
      check_eq("R3 all-zero u0", int'(res8), 0);

      // R8 and R10: gaps and strobes without data inside a batch
      cur_req = "R8";
      for (int i = 0; i < 8; i++) begin
         drive(1'b1, 8'($urandom), 8'($urandom), 1'b0, 1'b0);
         drive(1'b0, 8'hFF, 8'hFF, 1'b0, 1'b0);
      end
      cur_req = "R10";
      drive(1'b0, 8'hFF, 8'hFF, 1'b1, 1'b1);
      drive(1'b0, 8'hFF, 8'hFF, 1'b1, 1'b0);
      idle(3);
      check_eq("R10 no spurious pulse", q_due.size(), 0);
      rand_batch(9, 1'b1);
      idle(5);

      // R7: back-to-back one-bit batches, last on every other
      cur_req = "R7";
      for (int i = 0; i < 24; i++)
         drive(1'b1, 8'($urandom), 8'($urandom), 1'b1, i[0]);
      for (int i = 0; i < 6; i++)
         drive(1'b1, 8'hFF, 8'hFF, 1'b1, 1'b1);
      idle(5);

      // R4/R6: many batches, varied lengths, consecutive outputs
      cur_req = "R4";
      for (int o = 0; o < 3; o++)
         for (int b = 0; b < 5; b++) rand_batch(1 + (b * 7 + o) % 30, b == 4);
      cur_req = "R6";
      rand_batch(64, 1'b1);
      rand_batch(5, 1'b1);
      idle(5);

      // R1: exact AND coincidences on lane 0
      cur_req = "R1";
      for (int i = 0; i < 20; i++) drive(1'b1, 8'h01, 8'(i % 3 == 0), i == 19, 1'b1);
      idle(4);
      check_eq("R1 lane0 count", int'(res1), 7);
      check_eq("R5 queue drained", q_due.size(), 0);
      finish_run();
   end

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule